// File: doc/BRIEF.md
# Byte-Wide Counter Bus Port

This block places a wide counter (two or three bytes) on an 8-bit processor bus. The processor reads the counter one byte at a time. A read with chip select and read strobe both low takes a snapshot of the live counter into a holding register, and the addressed byte of that snapshot is presented on the data bus. The byte reads that follow return bytes of the same snapshot, so a multi-byte word read stays coherent while the counter keeps moving. A write loads one bus byte into the addressed byte of the counter through a one-cycle load strobe.

After reset the port learns the byte order from the first read. It stores the byte-address value of that read, and from then on only reads at that address take a new snapshot. A word read is therefore consistent whether the processor fetches the low byte or the high byte first. Several ports can share an active-low load line. The first port to be read after reset becomes the master and pulses the line each time it takes a snapshot. A port that sees the line pulled low before its own first read becomes a slave and never starts a snapshot by itself. A low level on the line loads the holding register of any port. The counting logic itself sits outside this block: the live counter value comes in on a port, and byte loads go out on ports.

The strobes are brought into the clock domain through a two-flop stage. Ready goes low once the access has been seen on a clock edge. It returns high as soon as chip select or the strobe is released.

Top module: `cnt_bus_port`

## Requirements
- R1: Byte decode with the byte selects {bsel1_n,bsel0_n}: 2'b11 selects byte 0 (bits 7:0), 2'b10 selects byte 1 (bits 15:8), and bsel1_n low selects the top byte (bits 23:16 with the default three bytes), whatever bsel0_n is. The same decode serves reads and writes.
- R2: dout_oe is high exactly while cs_n and rd_n are both low. In that case dout carries the addressed byte of the holding register.
- R3: The read strobe passes a two-flop synchronizer. If cs_n and rd_n are first sampled low at rising edge k, the snapshot is taken at edge k+2, and a master drives ldl_drive high for exactly the one cycle after that edge.
- R4: The first read after reset stores its {bsel1_n,bsel0_n} value. Later reads take a snapshot only when their selects equal the stored value. Reads at other addresses return bytes of the existing snapshot.
- R5: If no load-line pulse comes before the first read after reset, the port becomes master and pulses ldl_drive once for each snapshot it takes. If ldl_in_n is sampled low before the first read, the port becomes a slave, never asserts ldl_drive and takes no snapshot of its own.
- R6: In either role, ldl_in_n sampled low at a rising edge loads the live counter into the holding register at that edge.
- R7: rdy_n goes low at the first rising edge that samples cs_n low together with rd_n or wr_n low. It returns high without waiting for a clock once cs_n or the strobe goes high.
- R8: A write (cs_n and wr_n low, same two-flop timing as R3) raises exactly one bit of cnt_ld for one cycle. That bit is the byte index decoded per R1, and din appears on cnt_ld_data.
- R9: While rst_n is low and an access is held on cs_n with rd_n or wr_n, rdy_n stays low. Reset clears the learned address and the role, so the next read is learned afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| bsel0_n | input | 1 | Byte select, low picks byte 1 when bsel1_n is high |
| bsel1_n | input | 1 | Byte select, low picks the top byte |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| dout_oe | output | 1 | Bus driver enable for dout |
| rdy_n | output | 1 | Ready, low while an access is being served |
| ldl_in_n | input | 1 | Shared load line as seen at the pin, active low |
| ldl_drive | output | 1 | Pull the shared load line low (open-drain enable) |
| cnt_val | input | 8*NBYTES | Live counter value |
| cnt_ld | output | NBYTES | One-hot byte load strobe toward the counter |
| cnt_ld_data | output | 8 | Byte to be loaded into the counter |

## Verification
The assertions check the following on every cycle: ldl_drive and cnt_ld never last longer than one cycle, cnt_ld is one-hot or zero, and each pulse follows an access three edges earlier. They also check that rdy_n is low only while an access is on the pins. Only the bench scenarios can show snapshot coherence across a multi-byte read while the counter changes, which byte order was learned after each reset, the slave decision caused by an early line pulse, loads from the external line, and the byte decode of reads and writes. The bench sweeps counter values and write data arithmetically in both byte orders, in both roles and at every byte address.

// File: rtl/cbp_pkg.sv
// Shared types and helpers for the byte-wide counter bus port.
// Assumes at least two counter bytes.
package cbp_pkg;

    // Role of the port on the shared load line
    typedef enum logic [1:0] {
        ROLE_FREE   = 2'd0,
        ROLE_MASTER = 2'd1,
        ROLE_SLAVE  = 2'd2
    } role_e;

    // Byte index from the active-low selects: bsel1_n low -> top byte,
    // else bsel0_n low -> byte 1, else byte 0.
    function automatic int unsigned byte_index(input logic sel0_n,
                                               input logic sel1_n,
                                               input int unsigned nbytes);
        if (!sel1_n)
            return nbytes - 1;
        else if (!sel0_n)
            return 1;
        else
            return 0;
    endfunction

endpackage

// File: rtl/cbp_strobe_sync.sv
// Synchronizes an asynchronous active-high access level through STAGES
// flops and flags the first cycle it is seen asserted.
// Assumes STAGES >= 2 and that the level stays asserted for several cycles.
module cbp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_act,
    output logic start
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Shift the raw level through the synchronizer and keep one delayed copy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], raw_act};
            last_q  <= chain_q[STAGES-1];
        end
    end

    // Rising edge of the synchronized level
    assign start = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/cbp_load_ctrl.sv
// Decides when the holding register takes a snapshot: learns the byte
// address of the first read after reset, settles master/slave role on the
// shared load line and pulses the line as master.
// Assumes rd_start is a one-cycle synchronized read start.
module cbp_load_ctrl
    import cbp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_start,
    input  logic [1:0] sel_code,
    input  logic       ldl_in_n,
    output logic       snap_take,
    output logic       ldl_drive
);
    role_e      role_q;
    logic       learned_q;
    logic [1:0] code_q;
    logic       addr_ok;
    logic       may_lead;
    logic       gen;

    // Snapshot request from an own read: matching address and allowed to lead
    always_comb begin
        addr_ok  = !learned_q || (sel_code == code_q);
        may_lead = (role_q == ROLE_MASTER) || ((role_q == ROLE_FREE) && ldl_in_n);
        gen      = rd_start && addr_ok && may_lead;
    end

    // Learning of byte order, role decision and line pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            role_q    <= ROLE_FREE;
            learned_q <= 1'b0;
            code_q    <= 2'b11;
            ldl_drive <= 1'b0;
        end else begin
            if (rd_start && !learned_q) begin
                learned_q <= 1'b1;
                code_q    <= sel_code;
            end
            if (role_q == ROLE_FREE) begin
                if (!ldl_in_n)
                    role_q <= ROLE_SLAVE;
                else if (rd_start)
                    role_q <= ROLE_MASTER;
            end
            ldl_drive <= gen;
        end
    end

    // Own request or external line both load the holding register
    assign snap_take = gen || !ldl_in_n;

endmodule

// File: rtl/cbp_ready.sv
// Ready handshake: low from the first clock edge that sees an access and
// released combinationally when the access ends; held low through reset
// while an access is present.
module cbp_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic rdy_n
);
    logic acc;
    logic acc_q;

    // Access present on the pins
    assign acc = !cs_n && (!rd_n || !wr_n);

    // Record that the access has been seen on a clock edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= 1'b0;
        else
            acc_q <= acc;
    end

    // Ready low while a seen access lasts, or during reset with an access
    assign rdy_n = !(acc && (acc_q || !rst_n));

endmodule

// File: rtl/cbp_write_path.sv
// Turns a synchronized write start into a one-cycle one-hot byte load
// toward the counter, with the bus byte alongside.
// Assumes selects and data are stable while the write is held.
module cbp_write_path
    import cbp_pkg::*;
#(
    parameter int NBYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_start,
    input  logic              sel0_n,
    input  logic              sel1_n,
    input  logic [7:0]        din,
    output logic [NBYTES-1:0] cnt_ld,
    output logic [7:0]        cnt_ld_data
);
    localparam int IW = $clog2(NBYTES);

    logic [IW-1:0]     wr_idx;
    logic [NBYTES-1:0] ld_next;

    // Decode the addressed byte
    assign wr_idx = IW'(byte_index(sel0_n, sel1_n, NBYTES));

    // One strobe bit per counter byte
    for (genvar g = 0; g < NBYTES; g++) begin : g_ld
        assign ld_next[g] = wr_start && (wr_idx == IW'(g));
    end

    // Register the strobe and the data byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_ld      <= '0;
            cnt_ld_data <= '0;
        end else begin
            cnt_ld <= ld_next;
            if (wr_start)
                cnt_ld_data <= din;
        end
    end

endmodule

// File: rtl/cnt_bus_port.sv
// Byte-wide bus port for a multi-byte counter: synchronized read and write
// strobes, coherent snapshot with learned byte order, master/slave load
// line, ready handshake and byte loads toward the counter.
// Assumes NBYTES is 2 or 3 and bus pins are held stable during an access.
module cnt_bus_port
    import cbp_pkg::*;
#(
    parameter int NBYTES      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  rd_n,
    input  logic                  wr_n,
    input  logic                  bsel0_n,
    input  logic                  bsel1_n,
    input  logic [7:0]            din,
    output logic [7:0]            dout,
    output logic                  dout_oe,
    output logic                  rdy_n,
    input  logic                  ldl_in_n,
    output logic                  ldl_drive,
    input  logic [8*NBYTES-1:0]   cnt_val,
    output logic [NBYTES-1:0]     cnt_ld,
    output logic [7:0]            cnt_ld_data
);
    localparam int CW = 8 * NBYTES;
    localparam int IW = $clog2(NBYTES);

    logic          rd_start;
    logic          wr_start;
    logic          snap_take;
    logic [CW-1:0] snap_q;
    logic [IW-1:0] rd_idx;

    // Read strobe synchronizer
    cbp_strobe_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_act (!cs_n && !rd_n),
        .start   (rd_start)
    );

    // Write strobe synchronizer
    cbp_strobe_sync #(.STAGES(SYNC_STAGES)) u_wr_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw_act (!cs_n && !wr_n),
        .start   (wr_start)
    );

    // Snapshot decision and load line
    cbp_load_ctrl u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_start  (rd_start),
        .sel_code  ({bsel1_n, bsel0_n}),
        .ldl_in_n  (ldl_in_n),
        .snap_take (snap_take),
        .ldl_drive (ldl_drive)
    );

    // Ready handshake
    cbp_ready u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .rdy_n (rdy_n)
    );

    // Byte loads toward the counter
    cbp_write_path #(.NBYTES(NBYTES)) u_wr (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_start    (wr_start),
        .sel0_n      (bsel0_n),
        .sel1_n      (bsel1_n),
        .din         (din),
        .cnt_ld      (cnt_ld),
        .cnt_ld_data (cnt_ld_data)
    );

    // Holding register for the counter snapshot
    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= '0;
        else if (snap_take)
            snap_q <= cnt_val;
    end

    // Byte multiplexer and bus driver enable
    always_comb begin
        rd_idx  = IW'(byte_index(bsel0_n, bsel1_n, NBYTES));
        dout    = snap_q[rd_idx*8 +: 8];
        dout_oe = !cs_n && !rd_n;
    end

endmodule

// File: rtl/cbp_checker.sv
// Cycle checks on the bus port's pins, attached by bind.
module cbp_checker #(
    parameter int NBYTES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              rdy_n,
    input logic              ldl_drive,
    input logic [NBYTES-1:0] cnt_ld
);
    // R3
    drive_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ldl_drive |=> !ldl_drive);

    // R3
    drive_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ldl_drive |-> $past(!cs_n && !rd_n, 3));

    // R8
    ld_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cnt_ld));

    // R8
    ld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cnt_ld) |=> (cnt_ld == '0));

    // R8
    ld_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|cnt_ld) |-> $past(!cs_n && !wr_n, 3));

    // R7
    rdy_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rdy_n |-> (!cs_n && (!rd_n || !wr_n)));

endmodule

bind cnt_bus_port cbp_checker #(.NBYTES(NBYTES)) u_cbp_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .rdy_n     (rdy_n),
    .ldl_drive (ldl_drive),
    .cnt_ld    (cnt_ld)
);

// File: tb/cnt_bus_port_bench.sv
`timescale 1ns/1ps
module cnt_bus_port_bench;
    localparam int NB = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic          bsel0_n = 1'b1, bsel1_n = 1'b1;
    logic [7:0]    din = '0;
    logic [7:0]    dout;
    logic          dout_oe, rdy_n, ldl_drive;
    logic          ldl_in_n = 1'b1;
    logic [8*NB-1:0] cnt_val = '0;
    logic [NB-1:0] cnt_ld;
    logic [7:0]    cnt_ld_data;

    int checks = 0, fails = 0;
    int drv_cnt = 0, ld_hits = 0;
    logic [NB-1:0] ld_vec;
    logic [7:0]    ld_dat;
    bit finished = 0;

    always #10 clk = ~clk;

    cnt_bus_port #(.NBYTES(NB)) u_cnt_bus_port (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .bsel0_n(bsel0_n), .bsel1_n(bsel1_n), .din(din), .dout(dout),
        .dout_oe(dout_oe), .rdy_n(rdy_n), .ldl_in_n(ldl_in_n),
        .ldl_drive(ldl_drive), .cnt_val(cnt_val), .cnt_ld(cnt_ld),
        .cnt_ld_data(cnt_ld_data)
    );

    // Pulse monitors sampled away from the active edge
    always @(negedge clk) begin
        if (ldl_drive) drv_cnt++;
        if (|cnt_ld) begin
            ld_hits++;
            ld_vec = cnt_ld;
            ld_dat = cnt_ld_data;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // Byte select pairs: idx 0 -> (1,1), idx 1 -> (0,1), idx 2 -> (1,0)
    task automatic set_sel(input int idx);
        bsel0_n = (idx == 1) ? 1'b0 : 1'b1;
        bsel1_n = (idx == 2) ? 1'b0 : 1'b1;
    endtask

    task automatic rd_byte(input logic s0, input logic s1, output logic [7:0] b);
        @(negedge clk);
        bsel0_n = s0; bsel1_n = s1; cs_n = 1'b0; rd_n = 1'b0;
        repeat (5) @(negedge clk);
        b = dout;
        chk(dout_oe == 1'b1, "R2 oe during read", int'(dout_oe), 1);
        chk(rdy_n == 1'b0, "R7 ready low in read", int'(rdy_n), 0);
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
        chk(rdy_n == 1'b1, "R7 ready release", int'(rdy_n), 1);
        chk(dout_oe == 1'b0, "R2 oe off after read", int'(dout_oe), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_idx(input int idx, output logic [7:0] b);
        logic s0, s1;
        s0 = (idx == 1) ? 1'b0 : 1'b1;
        s1 = (idx == 2) ? 1'b0 : 1'b1;
        rd_byte(s0, s1, b);
    endtask

    task automatic ext_pulse();
        @(negedge clk); ldl_in_n = 1'b0;
        @(negedge clk); ldl_in_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_byte(input int idx, input logic [7:0] d);
        @(negedge clk);
        ld_hits = 0; ld_vec = '0; ld_dat = '0;
        set_sel(idx); din = d; cs_n = 1'b0; wr_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(rdy_n == 1'b0, "R7 ready low in write", int'(rdy_n), 0);
        chk(dout_oe == 1'b0, "R2 oe off in write", int'(dout_oe), 0);
        cs_n = 1'b1; wr_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ld_hits == 1, "R8 one load pulse", ld_hits, 1);
        chk(ld_vec == NB'(1 << idx), "R8 load byte R1 decode", int'(ld_vec), 1 << idx);
        chk(ld_dat == d, "R8 load data", int'(ld_dat), int'(d));
    endtask

    initial begin : main
        logic [8*NB-1:0] v;
        logic [7:0] b;
        int d0;

        do_reset();
        // Reset state
        chk(rdy_n == 1'b1, "R9 reset rdy", int'(rdy_n), 1);
        chk(dout_oe == 1'b0, "R2 reset oe", int'(dout_oe), 0);
        chk(ldl_drive == 1'b0, "R5 reset drive", int'(ldl_drive), 0);
        chk(cnt_ld == '0, "R8 reset load", int'(cnt_ld), 0);

        // R2: read strobe without chip select leaves the bus undriven
        @(negedge clk); rd_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(dout_oe == 1'b0, "R2 no cs", int'(dout_oe), 0);
        chk(rdy_n == 1'b1, "R7 no cs", int'(rdy_n), 1);
        chk(drv_cnt == 0, "R3 no cs no pulse", drv_cnt, 0);
        rd_n = 1'b1;
        repeat (2) @(negedge clk);

        // Low byte first: becomes master, learns byte 0 address (R1, R3, R4, R5)
        for (int i = 0; i < 16; i++) begin
            v = (8*NB)'((i + 1) * 24'h0F1E2D) ^ (8*NB)'(i << 19);
            cnt_val = v;
            d0 = drv_cnt;
            rd_idx(0, b);
            chk(b == v[7:0], "R1 R3 low byte", int'(b), int'(v[7:0]));
            cnt_val = v + 24'h010101;
            rd_idx(1, b);
            chk(b == v[15:8], "R4 mid byte coherent", int'(b), int'(v[15:8]));
            cnt_val = v + 24'h020202;
            rd_idx(2, b);
            chk(b == v[23:16], "R4 top byte coherent", int'(b), int'(v[23:16]));
            chk(drv_cnt == d0 + 1, "R5 one master pulse per word", drv_cnt - d0, 1);
        end
        // R1: both selects low read the top byte, no new snapshot
        cnt_val = 24'hABCDEF;
        rd_byte(1'b0, 1'b0, b);
        chk(b == v[23:16], "R1 top byte with both low", int'(b), int'(v[23:16]));

        // R6: external line loads while master
        cnt_val = 24'h5A6B7C;
        d0 = drv_cnt;
        ext_pulse();
        cnt_val = 24'h000000;
        rd_idx(1, b);
        chk(b == 8'h6B, "R6 external load master", int'(b), 8'h6B);
        chk(drv_cnt == d0, "R4 no pulse off address", drv_cnt - d0, 0);

        // R9: reset, then top byte first is learned
        do_reset();
        for (int i = 0; i < 8; i++) begin
            v = (8*NB)'((i + 3) * 24'h13579B);
            cnt_val = v;
            d0 = drv_cnt;
            rd_idx(2, b);
            chk(b == v[23:16], "R9 R4 top byte first", int'(b), int'(v[23:16]));
            cnt_val = ~v;
            rd_idx(1, b);
            chk(b == v[15:8], "R4 mid after top", int'(b), int'(v[15:8]));
            rd_idx(0, b);
            chk(b == v[7:0], "R4 low after top", int'(b), int'(v[7:0]));
            chk(drv_cnt == d0 + 1, "R5 pulse on learned top", drv_cnt - d0, 1);
        end

        // R5: slave when the line pulses before the first read
        do_reset();
        cnt_val = 24'h123456;
        ext_pulse();
        cnt_val = 24'h777777;
        d0 = drv_cnt;
        rd_idx(0, b);
        chk(b == 8'h56, "R5 slave low", int'(b), 8'h56);
        rd_idx(2, b);
        chk(b == 8'h12, "R5 slave top", int'(b), 8'h12);
        chk(drv_cnt == d0, "R5 slave silent", drv_cnt - d0, 0);
        cnt_val = 24'h9ABCDE;
        ext_pulse();
        cnt_val = 24'h000000;
        rd_idx(0, b);
        chk(b == 8'hDE, "R6 slave external load", int'(b), 8'hDE);
        rd_idx(1, b);
        chk(b == 8'hBC, "R6 slave mid", int'(b), 8'hBC);

        // R8: writes at every byte with a data sweep
        for (int idx = 0; idx < NB; idx++)
            for (int k = 0; k < 16; k++)
                wr_byte(idx, 8'((k * 17 + idx * 5) & 8'hFF));

        // R9: ready held low while reset is held during an access
        @(negedge clk); cs_n = 1'b0; rd_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(rdy_n == 1'b0, "R9 ready low in reset", int'(rdy_n), 0);
        cs_n = 1'b1; rd_n = 1'b1;
        #1;
        chk(rdy_n == 1'b1, "R9 ready after release", int'(rdy_n), 1);
        @(negedge clk); rst_n = 1'b1;
        repeat (2) @(negedge clk);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule